// File: doc/BRIEF.md
# Three-Level Clamped Leg Gate Sequencer

This block drives the six gate enables of each leg of a three-phase, three-level converter in which every leg has an upper and a lower slow switch that select the half cycle, and two fast pairs that alternate between an active state and a freewheel state. Each phase is controlled by two inputs: a fast PWM that selects active (high) or freewheel (low), and a polarity bit that selects the positive (high) or negative (low) half cycle. The sequencer expands these two bits into the six enables. During the active state it also turns on the clamp switch of the opposite half, so that the voltage across the idle devices is shared.

Each PWM edge passes through a dead interval of a programmable number of clocks. During that interval only the slow switch of the current half stays on. A polarity change first holds the whole leg off for a fixed guard interval, and only then is the new half applied. A global latched fault removes every gate within one clock. A registered interlock check blocks any leg whose decoded enables would turn on both members of a complementary pair.

Top module: `anpc_gate_seq`

## Requirements
- R1: After reset, `gateOut` and `faultLatched` are all zero and `interlockHit` is low. Each leg starts in the guard state, with all of its gates off, for GUARD_CYCLES clocks.
- R2: The gate bits of phase p are `gateOut[6p+k]`, where k=0 is the main upper fast switch, k=1 the upper clamp fast switch, k=2 the main lower fast switch, k=3 the lower clamp fast switch, k=4 the upper slow switch and k=5 the lower slow switch. In the positive active state (polarity 1, PWM 1), bits 0, 3 and 4 are on.
- R3: In the positive freewheel state (polarity 1, PWM 0), bits 1 and 4 are on.
- R4: In the negative active state (polarity 0, PWM 1), bits 1, 2 and 5 are on. In the negative freewheel state (polarity 0, PWM 0), bits 3 and 5 are on.
- R5: An edge on a phase's PWM while that phase is active or freewheeling starts a dead interval of `deadCycles` clocks. During this interval only the slow switch of the applied half is on. At its end the state follows the PWM level present at that time.
- R6: When `deadCycles` is zero, a PWM edge moves the leg straight between the active and freewheel patterns, with no dead interval.
- R7: When a phase's polarity differs from the applied half, the leg enters a guard state with all six gates off for GUARD_CYCLES clocks. After that it applies the new half and the PWM level present at that time.
- R8: The two slow switches of a phase are never on together. A slow switch turns on only after a cycle in which all six gates of its phase were off.
- R9: Any bit of `faultIn` sets `faultLatched` at the next clock and forces all gates to zero at that same clock. While the flag is set, every leg is held in the guard state.
- R10: `faultLatched` clears only on a clock where `faultClr` is high and no `faultIn` bit is set. After it clears, each leg runs a full guard interval before any gate turns on.
- R11: No phase ever has bits 0 and 1, or bits 2 and 3, on together. A decoded pattern that would do so is replaced by all-off, and `interlockHit` is raised for one clock.
- R12: A change on `pwmIn` or `polIn` that is present before clock edge k takes effect on `gateOut` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | NUM_PHASES | Per-phase fast PWM, 1 = active, 0 = freewheel |
| polIn | input | NUM_PHASES | Per-phase half-cycle polarity, 1 = positive |
| deadCycles | input | DT_W | Dead interval length in clocks, taken from a control register |
| faultIn | input | 6*NUM_PHASES | Per-device fault inputs |
| faultClr | input | 1 | Request to clear the latched fault |
| gateOut | output | 6*NUM_PHASES | Registered gate enables, six per phase |
| faultLatched | output | 1 | Latched fault flag |
| interlockHit | output | 1 | A forbidden pair was blocked on the last clock |

## Verification
A leg whose internal state is wrong shows up at `gateOut` two clocks after the stimulus that should have moved it. Possible symptoms are a dead or guard interval that is one clock too long or too short, a clamp switch on the wrong half, or a slow switch that stays on across a polarity change. A fault latch that is wrong shows up one clock after the fault or the clear: a gate remains on, or the restart guard is missing. A behavioural model predicts every gate bit on every clock, so the first cycle that diverges is reported together with the requirement of the state the model expected.

// File: rtl/anpc_pkg.sv
package anpc_pkg;

  // Leg sequencing states
  typedef enum logic [1:0] {
    ST_GUARD = 2'd0,  // whole leg off
    ST_DEAD  = 2'd1,  // only slow switch of applied half on
    ST_ACT   = 2'd2,  // active pattern
    ST_FW    = 2'd3   // freewheel pattern
  } legState_t;

  // Strobe set sent from control to datapath for one leg
  typedef struct packed {
    legState_t state;
    logic      posHalf;
  } legCmd_t;

  // Gate bit positions inside a six-bit leg group
  localparam int G_MAIN_HI  = 0;
  localparam int G_CLAMP_HI = 1;
  localparam int G_MAIN_LO  = 2;
  localparam int G_CLAMP_LO = 3;
  localparam int G_SLOW_HI  = 4;
  localparam int G_SLOW_LO  = 5;
  localparam int LEG_GATES  = 6;

endpackage

// File: rtl/anpc_seq_ctrl.sv
module anpc_seq_ctrl
  import anpc_pkg::*;
#(
  parameter int NUM_PHASES   = 3,
  parameter int DT_W         = 8,
  parameter int GUARD_CYCLES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PHASES-1:0]            pwmIn,
  input  logic [NUM_PHASES-1:0]            polIn,
  input  logic [DT_W-1:0]                  deadCycles,
  input  logic [LEG_GATES*NUM_PHASES-1:0]  faultIn,
  input  logic                             faultClr,
  output legCmd_t [NUM_PHASES-1:0]         cmd,
  output logic                             stopAll,
  output logic                             faultLatched
);

  localparam int GUARD_W = $clog2(GUARD_CYCLES + 1);
  localparam int CNT_W   = (DT_W > GUARD_W) ? DT_W : GUARD_W;

  logic anyFault;
  logic [CNT_W:0] deadLim;
  logic [CNT_W:0] guardLim;

  assign anyFault = |faultIn;
  assign stopAll  = faultLatched | anyFault;
  assign deadLim  = (CNT_W+1)'(deadCycles);
  assign guardLim = (CNT_W+1)'(GUARD_CYCLES);

  // Fault flag: set by any fault, cleared only by a clean clear request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLatched <= 1'b0;
    end else if (anyFault) begin
      faultLatched <= 1'b1;
    end else if (faultClr) begin
      faultLatched <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : gLeg
    legState_t      state;
    logic           appliedPol;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0] cntInc;

    assign cntInc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        state      <= ST_GUARD;
        cnt        <= '0;
        appliedPol <= 1'b1;
      end else if (stopAll) begin
        state <= ST_GUARD;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_GUARD: begin
            if (cntInc >= guardLim) begin
              appliedPol <= polIn[p];
              state      <= pwmIn[p] ? ST_ACT : ST_FW;
              cnt        <= '0;
            end else begin
              cnt <= cntInc[CNT_W-1:0];
            end
          end
          ST_DEAD: begin
            if (polIn[p] != appliedPol) begin
              state <= ST_GUARD;
              cnt   <= '0;
            end else if (cntInc >= deadLim) begin
              state <= pwmIn[p] ? ST_ACT : ST_FW;
              cnt   <= '0;
            end else begin
              cnt <= cntInc[CNT_W-1:0];
            end
          end
          ST_ACT, ST_FW: begin
            if (polIn[p] != appliedPol) begin
              state <= ST_GUARD;
              cnt   <= '0;
            end else if (pwmIn[p] != (state == ST_ACT)) begin
              cnt <= '0;
              if (deadCycles == '0) begin
                state <= pwmIn[p] ? ST_ACT : ST_FW;
              end else begin
                state <= ST_DEAD;
              end
            end
          end
          default: begin
            state <= ST_GUARD;
            cnt   <= '0;
          end
        endcase
      end
    end

    assign cmd[p].state   = state;
    assign cmd[p].posHalf = appliedPol;
  end

endmodule

// File: rtl/anpc_gate_path.sv
module anpc_gate_path
  import anpc_pkg::*;
#(
  parameter int NUM_PHASES = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  legCmd_t [NUM_PHASES-1:0]         cmd,
  input  logic                             stopAll,
  output logic [LEG_GATES*NUM_PHASES-1:0]  gateOut,
  output logic                             interlockHit
);

  localparam int TOTAL_GATES = LEG_GATES * NUM_PHASES;

  logic [TOTAL_GATES-1:0] rawAll;
  logic [NUM_PHASES-1:0]  conflict;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : gDec
    logic [LEG_GATES-1:0] raw;

    always_comb begin
      raw = '0;
      unique case (cmd[p].state)
        ST_ACT: begin
          if (cmd[p].posHalf) begin
            raw[G_MAIN_HI]  = 1'b1;
            raw[G_CLAMP_LO] = 1'b1;
            raw[G_SLOW_HI]  = 1'b1;
          end else begin
            raw[G_MAIN_LO]  = 1'b1;
            raw[G_CLAMP_HI] = 1'b1;
            raw[G_SLOW_LO]  = 1'b1;
          end
        end
        ST_FW: begin
          if (cmd[p].posHalf) begin
            raw[G_CLAMP_HI] = 1'b1;
            raw[G_SLOW_HI]  = 1'b1;
          end else begin
            raw[G_CLAMP_LO] = 1'b1;
            raw[G_SLOW_LO]  = 1'b1;
          end
        end
        ST_DEAD: begin
          raw[G_SLOW_HI] = cmd[p].posHalf;
          raw[G_SLOW_LO] = ~cmd[p].posHalf;
        end
        default: raw = '0;
      endcase
    end

    assign rawAll[p*LEG_GATES +: LEG_GATES] = raw;
    assign conflict[p] = (raw[G_MAIN_HI] & raw[G_CLAMP_HI]) |
                         (raw[G_MAIN_LO] & raw[G_CLAMP_LO]) |
                         (raw[G_SLOW_HI] & raw[G_SLOW_LO]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOut      <= '0;
      interlockHit <= 1'b0;
    end else begin
      interlockHit <= ~stopAll & (|conflict);
      for (int p = 0; p < NUM_PHASES; p++) begin
        if (stopAll || conflict[p]) begin
          gateOut[p*LEG_GATES +: LEG_GATES] <= '0;
        end else begin
          gateOut[p*LEG_GATES +: LEG_GATES] <= rawAll[p*LEG_GATES +: LEG_GATES];
        end
      end
    end
  end

endmodule

// File: rtl/anpc_gate_seq.sv
module anpc_gate_seq
  import anpc_pkg::*;
#(
  parameter int NUM_PHASES   = 3,
  parameter int DT_W         = 8,
  parameter int GUARD_CYCLES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PHASES-1:0]            pwmIn,
  input  logic [NUM_PHASES-1:0]            polIn,
  input  logic [DT_W-1:0]                  deadCycles,
  input  logic [6*NUM_PHASES-1:0]          faultIn,
  input  logic                             faultClr,
  output logic [6*NUM_PHASES-1:0]          gateOut,
  output logic                             faultLatched,
  output logic                             interlockHit
);

  legCmd_t [NUM_PHASES-1:0] cmd;
  logic stopAll;

  anpc_seq_ctrl #(
    .NUM_PHASES  (NUM_PHASES),
    .DT_W        (DT_W),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pwmIn       (pwmIn),
    .polIn       (polIn),
    .deadCycles  (deadCycles),
    .faultIn     (faultIn),
    .faultClr    (faultClr),
    .cmd         (cmd),
    .stopAll     (stopAll),
    .faultLatched(faultLatched)
  );

  anpc_gate_path #(
    .NUM_PHASES(NUM_PHASES)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .stopAll     (stopAll),
    .gateOut     (gateOut),
    .interlockHit(interlockHit)
  );

endmodule

// File: rtl/anpc_gate_seq_chk.sv
module anpc_gate_seq_chk #(
  parameter int NUM_PHASES = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [6*NUM_PHASES-1:0]   faultIn,
  input logic                      faultClr,
  input logic [6*NUM_PHASES-1:0]   gateOut,
  input logic                      faultLatched,
  input logic                      interlockHit
);

  AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (|faultIn) |=> (gateOut == '0)) else $error("fault did not clear gates"); // R9

  AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (|faultIn) |=> faultLatched) else $error("fault flag not set"); // R9

  AST_FAULT_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !faultClr) |=> faultLatched) else $error("fault flag dropped"); // R10

  AST_NO_INTERLOCK_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !interlockHit) else $error("interlock blocked a pattern"); // R11

  for (genvar p = 0; p < NUM_PHASES; p++) begin : gLegChk
    AST_SLOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      !(gateOut[6*p+4] && gateOut[6*p+5])) else $error("both slow switches on"); // R8

    AST_UPPER_PAIR_SAFE: assert property (@(posedge clk) disable iff (!rstN)
      !(gateOut[6*p+0] && gateOut[6*p+1])) else $error("upper pair overlap"); // R11

    AST_LOWER_PAIR_SAFE: assert property (@(posedge clk) disable iff (!rstN)
      !(gateOut[6*p+2] && gateOut[6*p+3])) else $error("lower pair overlap"); // R11

    AST_SLOW_HI_AFTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateOut[6*p+4]) |-> ($past(gateOut[6*p +: 6]) == 6'd0))
      else $error("upper slow switch rose without guard"); // R8

    AST_SLOW_LO_AFTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateOut[6*p+5]) |-> ($past(gateOut[6*p +: 6]) == 6'd0))
      else $error("lower slow switch rose without guard"); // R8
  end

endmodule

bind anpc_gate_seq anpc_gate_seq_chk #(
  .NUM_PHASES(NUM_PHASES)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .faultIn     (faultIn),
  .faultClr    (faultClr),
  .gateOut     (gateOut),
  .faultLatched(faultLatched),
  .interlockHit(interlockHit)
);

// File: tb/anpc_gate_seq_test.sv
module anpc_gate_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 3;
  localparam int DTW        = 8;
  localparam int GUARD      = 4;
  localparam int NG         = 6 * NP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]  pwmIn = '0;
  logic [NP-1:0]  polIn = '1;
  logic [DTW-1:0] deadCycles = 8'd3;
  logic [NG-1:0]  faultIn = '0;
  logic faultClr = 1'b0;
  logic [NG-1:0]  gateOut;
  logic faultLatched;
  logic interlockHit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  anpc_gate_seq #(.NUM_PHASES(NP), .DT_W(DTW), .GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .polIn(polIn),
    .deadCycles(deadCycles), .faultIn(faultIn), .faultClr(faultClr),
    .gateOut(gateOut), .faultLatched(faultLatched), .interlockHit(interlockHit)
  );

  // Behavioural reference: mode 0 guard, 1 dead, 2 active, 3 freewheel
  int mMode [NP];
  int mCnt  [NP];
  int mPol  [NP];
  bit mFault;
  logic [NG-1:0] expGate;
  string expTag [NP];

  // Expected six-bit leg pattern, bit order per R2
  function automatic logic [5:0] legPattern(int mode, int pol);
    logic [5:0] v = 6'd0;
    if (mode == 2 && pol == 1) begin v[0] = 1; v[3] = 1; v[4] = 1; end      // R2
    else if (mode == 3 && pol == 1) begin v[1] = 1; v[4] = 1; end           // R3
    else if (mode == 2 && pol == 0) begin v[2] = 1; v[1] = 1; v[5] = 1; end // R4
    else if (mode == 3 && pol == 0) begin v[3] = 1; v[5] = 1; end           // R4
    else if (mode == 1) begin if (pol == 1) v[4] = 1; else v[5] = 1; end    // R5
    return v;
  endfunction

  function automatic string modeTag(int mode, int pol, bit stop);
    if (stop) return "R9";
    case (mode)
      0: return "R7";
      1: return "R5";
      2: return (pol == 1) ? "R2" : "R4";
      default: return (pol == 1) ? "R3" : "R4";
    endcase
  endfunction

  // Model: the gates after an edge reflect the mode held before it, so an
  // input change reaches the gates one clock after the mode moves (R12)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin
        mMode[p] = 0; mCnt[p] = 0; mPol[p] = 1; expTag[p] = "R1";
      end
      mFault = 0;
      expGate = '0;
    end else begin
      bit stop;
      stop = mFault || (faultIn != '0);
      for (int p = 0; p < NP; p++) begin
        expGate[6*p +: 6] = stop ? 6'd0 : legPattern(mMode[p], mPol[p]);
        expTag[p] = modeTag(mMode[p], mPol[p], stop);
      end
      if (faultIn != '0) mFault = 1;
      else if (faultClr) mFault = 0;   // R10
      for (int p = 0; p < NP; p++) begin
        if (stop) begin
          mMode[p] = 0; mCnt[p] = 0;
        end else if (mMode[p] == 0) begin
          if (mCnt[p] + 1 >= GUARD) begin
            mPol[p] = int'(polIn[p]); mMode[p] = pwmIn[p] ? 2 : 3; mCnt[p] = 0;
          end else mCnt[p]++;
        end else if (int'(polIn[p]) != mPol[p]) begin
          mMode[p] = 0; mCnt[p] = 0;   // R7
        end else if (mMode[p] == 1) begin
          if (mCnt[p] + 1 >= int'(deadCycles)) begin
            mMode[p] = pwmIn[p] ? 2 : 3; mCnt[p] = 0;
          end else mCnt[p]++;
        end else if (pwmIn[p] != (mMode[p] == 2)) begin
          mCnt[p] = 0;
          if (deadCycles == 0) mMode[p] = pwmIn[p] ? 2 : 3;  // R6
          else mMode[p] = 1;
        end
      end
    end
  end

  // Cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (gateOut[6*p +: 6] !== expGate[6*p +: 6]) begin
          errors++;
          $display("FAIL %s phase %0d gates actual=%b expected=%b at %0t",
                   expTag[p], p, gateOut[6*p +: 6], expGate[6*p +: 6], $time);
        end
        checks++;
        if (gateOut[6*p+4] && gateOut[6*p+5]) begin
          errors++;
          $display("FAIL R8 phase %0d slow pair actual=11 expected=not both", p);
        end
      end
      checks++;
      if (faultLatched !== mFault) begin
        errors++;
        $display("FAIL R9/R10 faultLatched actual=%b expected=%b", faultLatched, mFault);
      end
      checks++;
      if (interlockHit !== 1'b0) begin
        errors++;
        $display("FAIL R11 interlockHit actual=%b expected=0", interlockHit);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic directCheck(string tag, logic [NG-1:0] act, logic [NG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    tick(3);
    rstN = 1'b1;
    // R1: reset state, then guard keeps everything off
    directCheck("R1", gateOut, '0);
    directCheck("R1", {{(NG-1){1'b0}}, faultLatched}, '0);
    tick(2);
    directCheck("R1", gateOut, '0);
    tick(GUARD + 2);
    // R2/R3/R5: positive half, dead time 3, differing PWM rates
    for (int c = 0; c < 80; c++) begin
      pwmIn[0] = ((c / 10) % 2) == 0;
      pwmIn[1] = ((c / 7) % 2) == 1;
      pwmIn[2] = 1'b1;
      tick(1);
    end
    // R7/R4: phase 1 flips to negative half
    polIn[1] = 1'b0;
    for (int c = 0; c < 60; c++) begin
      pwmIn = NP'(c / 6);
      tick(1);
    end
    // R6: zero dead time, direct transitions
    deadCycles = 8'd0;
    for (int c = 0; c < 40; c++) begin
      pwmIn = ~pwmIn;
      if (c % 3 == 0) pwmIn[2] = 1'b0;
      tick(1);
    end
    // R5: one-clock dead time and a PWM bounce inside a long dead time
    deadCycles = 8'd1;
    tick(4); pwmIn = 3'b101; tick(5); pwmIn = 3'b010; tick(5);
    deadCycles = 8'd6;
    pwmIn = 3'b111; tick(8); pwmIn = 3'b000; tick(2); pwmIn = 3'b111; tick(10);
    // R9: single-clock fault pulse
    faultIn[8] = 1'b1; tick(1); faultIn = '0;
    directCheck("R9", gateOut, '0);
    directCheck("R9", {{(NG-1){1'b0}}, faultLatched}, {{(NG-1){1'b0}}, 1'b1});
    tick(5);
    // R10: clear ignored while a fault is still present
    faultIn[17] = 1'b1; faultClr = 1'b1; tick(1);
    directCheck("R10", {{(NG-1){1'b0}}, faultLatched}, {{(NG-1){1'b0}}, 1'b1});
    faultIn = '0; tick(1); faultClr = 1'b0;
    tick(1);
    directCheck("R10", {{(NG-1){1'b0}}, faultLatched}, '0);
    directCheck("R10", gateOut, '0);
    tick(GUARD + 6);
    // Mixed pseudo-random run with polarity flips and occasional faults
    deadCycles = 8'd2;
    for (int c = 0; c < 2500; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] < 4'd5) pwmIn = lfsr[6:4];
      if (lfsr[11:7] == 5'd0) polIn = lfsr[14:12];
      if (c % 97 == 50) deadCycles = DTW'(lfsr[2:0]);
      faultIn = (c % 401 == 200) ? NG'(1) << (c % NG) : '0;
      faultClr = (c % 401 == 210);
      tick(1);
    end
    faultIn = '0; faultClr = 1'b0;
    tick(3);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule